// File: doc/BRIEF.md
# Block-Transfer Configuration Register Slave

This block is a two-wire serial slave that holds seven 8-bit configuration bytes for a clock generator and presents all of them in parallel to the surrounding logic. The bus runs at standard-mode rates (100 kbit/s or less). A fast system clock oversamples SCL and SDA through two-flop synchronizers. START is recognised as SDA falling while SCL is high, and STOP as SDA rising while SCL is high. The block drives SDA only through an open-drain enable, so a high enable pulls the line low.

The transfer protocol is fixed and contains no register pointer.

- **Write:** the master addresses the slave with D2h, then sends a command byte and a count byte. The slave acknowledges both and throws their contents away. Every byte after those two is stored in the next register, starting from register 0.
- **Read:** the master addresses the slave with D3h. The slave answers with a count byte of 07h and then registers 0 to 6 in order.

Register 6 is reserved and keeps its default value. Register 0 resets to 00h and all the others reset to FFh.

Top module: `cfg_i2c_slave`

## Requirements
- R1: The address bytes D2h (write) and D3h (read) are acknowledged. An acknowledge means the slave holds SDA low while SCL is high in the 9th clock of a byte. All bytes are sent MSB first.
- R2: Any other address byte gets no acknowledge. The slave then leaves SDA released and changes no register until the next START.
- R3: In a write, the first two bytes after the address are acknowledged and their values never reach any register.
- R4: In a write, data bytes land in register 0, 1, 2 and so on, in ascending order, and each one is acknowledged. Register i appears on `cfg_regs_o[8*i+7:8*i]`.
- R5: A STOP may follow any complete byte, and bytes written before it keep their new values. A register whose byte is cut short by STOP keeps its old value.
- R6: A read returns 07h first and then registers 0 through 6, with the master acknowledging each byte.
- R7: A master NACK during a read ends the transfer. SDA stays released, so any further clocks read 1, until the next START.
- R8: After reset, register 0 is 00h, registers 1 to 6 are FFh, and SDA is released.
- R9: Register 6 always holds FFh. Write data aimed at register 6 or beyond is acknowledged and discarded.
- R10: The slave only begins pulling SDA low while SCL is low. A STOP releases SDA.
- R11: A repeated START in the middle of a transfer restarts the address phase. A write that is followed by a repeated START and a read returns the freshly written data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System oversampling clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_oe_o | output | 1 | Open-drain enable: 1 pulls SDA low |
| cfg_regs_o | output | 56 | Register bank, register i at bits 8*i+7:8*i |

## Verification
Directed transfers cover the following cases:
- a full write that runs past the reserved register;
- a write cut off after the command byte;
- a write cut off in the middle of a data byte;
- a rejected address followed by more clocked bytes;
- a read ended early by a NACK, followed by clocks the slave must ignore;
- a write joined to a read-back by a repeated START.

Together these separate a slave that counts bytes wrongly, commits partial bytes, or keeps driving after it should have stopped. Random write lengths from zero to eight data bytes, with random contents, are each followed by a full read-back and a check of the parallel outputs. These runs show that the bytes land in the right registers, that the discarded leading bytes never leak into the bank, and that the reserved byte stays fixed.

// File: rtl/cfgi2c_pkg.sv
package cfgi2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,     // waiting for START (also used after a rejected address or NACK)
    ST_RXBITS,   // shifting in 8 bits on SCL rising edges
    ST_ACKWAIT,  // byte complete, wait for SCL low before pulling SDA
    ST_ACK,      // holding the acknowledge bit low
    ST_TXBITS,   // shifting out a byte, one bit per SCL falling edge
    ST_MACK,     // SDA released, sampling the master's acknowledge
    ST_TXWAIT    // master acked, wait for SCL low to present the next MSB
  } slv_state_e;

  // Power-on value of register idx.
  function automatic logic [7:0] reg_default(input int idx);
    return (idx == 0) ? 8'h00 : 8'hFF;
  endfunction

  // Beat = byte number after the address byte; beats 0 and 1 are discarded,
  // beat 2+k targets register k, which is writable only below nwr.
  function automatic logic beat_is_store(input int unsigned beat, input int unsigned nwr);
    return (beat >= 2) && (beat < nwr + 2);
  endfunction

  // Byte sent on read beat: beat 0 is the count, later beats come from the bank.
  function automatic logic [7:0] tx_pick(input logic is_count, input logic [7:0] count,
                                         input logic [7:0] bank_byte);
    return is_count ? count : bank_byte;
  endfunction

endpackage

// File: rtl/cfgi2c_line_sync.sv
module cfgi2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  // Bit STAGES-1 is the synchronized level, bit STAGES its previous value.
  logic [STAGES:0] scl_sh;
  logic [STAGES:0] sda_sh;
  logic scl_prev;
  logic sda_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
    end else begin
      scl_sh <= {scl_sh[STAGES-1:0], scl_i};
      sda_sh <= {sda_sh[STAGES-1:0], sda_i};
    end
  end

  assign scl_lvl  = scl_sh[STAGES-1];
  assign sda_lvl  = sda_sh[STAGES-1];
  assign scl_prev = scl_sh[STAGES];
  assign sda_prev = sda_sh[STAGES];

  assign scl_rise  = scl_lvl & ~scl_prev;
  assign scl_fall  = ~scl_lvl & scl_prev;
  assign start_det = scl_lvl & scl_prev & sda_prev & ~sda_lvl;
  assign stop_det  = scl_lvl & scl_prev & ~sda_prev & sda_lvl;
endmodule

// File: rtl/cfgi2c_regbank.sv
module cfgi2c_regbank
  import cfgi2c_pkg::*;
#(
  parameter int NUM_REGS = 7,
  parameter int NUM_WR   = 6,
  parameter int IDX_W    = 3,
  parameter int RIDX_W   = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  we,
  input  logic [IDX_W-1:0]      widx,
  input  logic [7:0]            wdata,
  input  logic [RIDX_W-1:0]     ridx,
  output logic [7:0]            rdata,
  output logic [NUM_REGS*8-1:0] regs_flat
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i < NUM_WR) begin : g_rw
      logic [7:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                             q <= reg_default(i);
        else if (we && widx == IDX_W'(i))       q <= wdata;
      end
      assign regs_flat[i*8 +: 8] = q;
    end else begin : g_fixed
      assign regs_flat[i*8 +: 8] = reg_default(i);
    end
  end

  always_comb begin
    rdata = 8'hFF;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (ridx == RIDX_W'(i)) rdata = regs_flat[i*8 +: 8];
    end
  end
endmodule

// File: rtl/cfg_i2c_slave.sv
module cfg_i2c_slave
  import cfgi2c_pkg::*;
#(
  parameter int         NUM_REGS    = 7,
  parameter int         NUM_WR      = 6,
  parameter logic [6:0] DEV_ADDR    = 7'h69,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe_o,
  output logic [NUM_REGS*8-1:0] cfg_regs_o
);
  localparam int                IDX_W      = $clog2(NUM_REGS);
  localparam int                BEAT_W     = $clog2(NUM_REGS + 3) + 1;
  localparam logic [BEAT_W-1:0] BEAT_MAX   = '1;
  localparam logic [7:0]        BYTE_COUNT = 8'(NUM_REGS);

  // Named internal events, also observed by the checker.
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
  logic byte_done, addr_hit, addr_reject, wr_commit;

  slv_state_e        st;
  logic [2:0]        bit_cnt;
  logic [7:0]        shreg;
  logic [BEAT_W-1:0] beat;
  logic              addr_phase;
  logic              rd_mode;
  logic              oe_q;

  logic [7:0]        rx_full;
  logic [BEAT_W-1:0] beat_m2;
  logic [BEAT_W-1:0] rd_idx;
  logic [7:0]        rd_data;
  logic [7:0]        tx_byte;
  logic [BEAT_W-1:0] beat_next;

  cfgi2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_lvl  (scl_lvl),
    .sda_lvl  (sda_lvl),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  assign rx_full     = {shreg[6:0], sda_lvl};
  assign byte_done   = (st == ST_RXBITS) && scl_rise && (bit_cnt == 3'd7);
  assign addr_hit    = (rx_full[7:1] == DEV_ADDR);
  assign addr_reject = byte_done && addr_phase && !addr_hit;
  assign wr_commit   = byte_done && !addr_phase && !rd_mode &&
                       beat_is_store(32'(beat), NUM_WR);
  assign beat_m2     = beat - BEAT_W'(2);
  assign rd_idx      = beat - BEAT_W'(1);
  assign beat_next   = (beat == BEAT_MAX) ? beat : beat + BEAT_W'(1);
  assign tx_byte     = tx_pick(beat == '0, BYTE_COUNT, rd_data);

  cfgi2c_regbank #(
    .NUM_REGS(NUM_REGS),
    .NUM_WR  (NUM_WR),
    .IDX_W   (IDX_W),
    .RIDX_W  (BEAT_W)
  ) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (wr_commit),
    .widx     (beat_m2[IDX_W-1:0]),
    .wdata    (rx_full),
    .ridx     (rd_idx),
    .rdata    (rd_data),
    .regs_flat(cfg_regs_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= ST_IDLE;
      bit_cnt    <= '0;
      shreg      <= '0;
      beat       <= '0;
      addr_phase <= 1'b0;
      rd_mode    <= 1'b0;
      oe_q       <= 1'b0;
    end else if (start_det) begin
      st         <= ST_RXBITS;
      bit_cnt    <= '0;
      beat       <= '0;
      addr_phase <= 1'b1;
      oe_q       <= 1'b0;
    end else if (stop_det) begin
      st   <= ST_IDLE;
      oe_q <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: ;
        ST_RXBITS: begin
          if (scl_rise) begin
            shreg   <= rx_full;
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              if (addr_phase) begin
                addr_phase <= 1'b0;
                if (addr_hit) begin
                  rd_mode <= rx_full[0];
                  st      <= ST_ACKWAIT;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                beat <= beat_next;
                st   <= ST_ACKWAIT;
              end
            end
          end
        end
        ST_ACKWAIT: begin
          if (scl_fall) begin
            oe_q <= 1'b1;
            st   <= ST_ACK;
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (rd_mode) begin
              oe_q  <= ~tx_byte[7];
              shreg <= {tx_byte[6:0], 1'b0};
              st    <= ST_TXBITS;
            end else begin
              oe_q <= 1'b0;
              st   <= ST_RXBITS;
            end
          end
        end
        ST_TXBITS: begin
          if (scl_fall) begin
            bit_cnt <= bit_cnt + 3'd1;
            if (bit_cnt == 3'd7) begin
              oe_q <= 1'b0;
              st   <= ST_MACK;
            end else begin
              oe_q  <= ~shreg[7];
              shreg <= {shreg[6:0], 1'b0};
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            if (sda_lvl) begin
              st <= ST_IDLE;
            end else begin
              beat <= beat_next;
              st   <= ST_TXWAIT;
            end
          end
        end
        ST_TXWAIT: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            oe_q    <= ~tx_byte[7];
            shreg   <= {tx_byte[6:0], 1'b0};
            st      <= ST_TXBITS;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign sda_oe_o = oe_q;
endmodule

// File: rtl/cfgi2c_checker.sv
module cfgi2c_checker #(
  parameter int NUM_REGS = 7
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  scl_lvl,
  input logic                  sda_oe,
  input logic                  stop_det,
  input logic                  addr_reject,
  input logic                  wr_commit,
  input logic [NUM_REGS*8-1:0] regs
);
  AST_DRIVE_ONLY_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl);  // R10

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !sda_oe);  // R10

  AST_REJECT_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    addr_reject |=> !sda_oe);  // R2

  AST_BANK_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_commit |=> $stable(regs));  // R5

  AST_RESERVED_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    regs[NUM_REGS*8-1 -: 8] == 8'hFF);  // R9
endmodule

bind cfg_i2c_slave cfgi2c_checker #(.NUM_REGS(NUM_REGS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .scl_lvl    (scl_lvl),
  .sda_oe     (sda_oe_o),
  .stop_det   (stop_det),
  .addr_reject(addr_reject),
  .wr_commit  (wr_commit),
  .regs       (cfg_regs_o)
);

// File: tb/test_cfg_i2c_slave.sv
module test_cfg_i2c_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 5;       // quarter bit time in system clocks
  localparam int NREG       = 7;
  localparam int NWR        = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic m_scl = 1'b1;
  logic m_sda = 1'b1;
  logic sda_oe;
  logic [NREG*8-1:0] regs;
  logic sda_line;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  int bad_drive = 0;
  logic prev_oe = 1'b0;
  logic [7:0] model [NREG];

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;

  cfg_i2c_slave i_cfg_i2c_slave (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_i     (m_scl),
    .sda_i     (sda_line),
    .sda_oe_o  (sda_oe),
    .cfg_regs_o(regs)
  );

  // R10: the slave may start pulling SDA only while SCL is low.
  always @(posedge clk) begin
    if (rst_n && sda_oe && !prev_oe && m_scl) bad_drive++;
    prev_oe <= sda_oe;
  end

  function automatic logic [NREG*8-1:0] model_flat();
    logic [NREG*8-1:0] v;
    for (int i = 0; i < NREG; i++) v[i*8 +: 8] = model[i];
    return v;
  endfunction

  function automatic logic [7:0] exp_read(input int k);
    return (k == 0) ? 8'h07 : ((k <= NREG) ? model[k-1] : 8'hFF);
  endfunction

  task automatic chk(input logic ok, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clk_bit(input logic b, output logic s);
    m_sda = b;  wait_cyc(Q);
    m_scl = 1'b1; wait_cyc(Q);
    s = sda_line; wait_cyc(Q);
    m_scl = 1'b0; wait_cyc(Q);
  endtask

  task automatic i2c_start();
    m_sda = 1'b1; wait_cyc(Q);
    m_scl = 1'b1; wait_cyc(Q);
    m_sda = 1'b0; wait_cyc(Q);
    m_scl = 1'b0; wait_cyc(Q);
  endtask

  task automatic i2c_stop();
    m_sda = 1'b0; wait_cyc(Q);
    m_scl = 1'b1; wait_cyc(Q);
    m_sda = 1'b1; wait_cyc(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic acked);
    logic s;
    for (int i = 7; i >= 0; i--) clk_bit(b[i], s);
    clk_bit(1'b1, s);
    acked = !s;
  endtask

  task automatic recv_byte(input logic mack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin
      clk_bit(1'b1, s);
      b[i] = s;
    end
    clk_bit(!mack, s);
  endtask

  task automatic write_txn(input int n, input logic [7:0] d [8]);
    logic a;
    i2c_start();
    send_byte(8'hD2, a);                     chk(a, "R1 write address ack", a, 1);
    send_byte(8'($urandom()), a);            chk(a, "R3 command byte ack", a, 1);
    send_byte(8'($urandom()), a);            chk(a, "R3 count byte ack", a, 1);
    for (int j = 0; j < n; j++) begin
      send_byte(d[j], a);
      chk(a, (j < NWR) ? "R4 data byte ack" : "R9 excess byte ack", a, 1);
      if (j < NWR) model[j] = d[j];
    end
    i2c_stop();
  endtask

  task automatic read_all(input string tag);
    logic a;
    logic [7:0] b;
    i2c_start();
    send_byte(8'hD3, a);
    chk(a, "R1 read address ack", a, 1);
    for (int k = 0; k <= NREG; k++) begin
      recv_byte(k < NREG, b);
      chk(b == exp_read(k), {"R6 read byte ", tag}, b, exp_read(k));
    end
    i2c_stop();
    chk(regs == model_flat(), {"R4 parallel outputs ", tag}, regs, model_flat());
  endtask

  initial begin
    logic a;
    logic [7:0] b;
    logic [7:0] d [8];
    void'($urandom(32'd20250613));
    for (int i = 0; i < NREG; i++) model[i] = (i == 0) ? 8'h00 : 8'hFF;
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(5);

    // R8: reset state
    chk(regs == {{6{8'hFF}}, 8'h00}, "R8 reset register values", regs, {{6{8'hFF}}, 8'h00});
    chk(sda_oe == 1'b0, "R8 SDA released after reset", sda_oe, 0);
    read_all("R8 defaults");

    // R3 R4 R9: full write running past the reserved register
    for (int j = 0; j < 8; j++) d[j] = 8'h31 + 8'(j * 17);
    write_txn(8, d);
    chk(regs[55:48] == 8'hFF, "R9 reserved register untouched", regs[55:48], 8'hFF);
    chk(regs[7:0] == d[0], "R3 register 0 holds first data byte", regs[7:0], d[0]);
    read_all("R4 full write");

    // R5: STOP after the command byte only
    i2c_start(); send_byte(8'hD2, a); send_byte(8'h00, a); i2c_stop();
    chk(regs == model_flat(), "R5 stop after command byte", regs, model_flat());

    // R5: STOP in the middle of the second data byte
    i2c_start(); send_byte(8'hD2, a); send_byte(8'h5A, a); send_byte(8'h02, a);
    send_byte(8'h11, a); model[0] = 8'h11;
    for (int i = 7; i >= 3; i--) clk_bit(1'b0, a);
    i2c_stop();
    chk(regs[7:0] == 8'h11, "R5 completed byte kept", regs[7:0], 8'h11);
    chk(regs[15:8] == model[1], "R5 partial byte discarded", regs[15:8], model[1]);

    // R2: wrong address, then more bytes while ignored
    i2c_start(); send_byte(8'hA0, a);
    chk(!a, "R2 foreign address not acked", a, 0);
    send_byte(8'h00, a);
    chk(!a, "R2 bus ignored after reject", a, 0);
    send_byte(8'h52, a);
    chk(!a, "R2 still ignored", a, 0);
    i2c_stop();
    chk(regs == model_flat(), "R2 registers unchanged", regs, model_flat());
    i2c_start(); send_byte(8'hD0, a);
    chk(!a, "R2 near-miss address not acked", a, 0);
    i2c_stop();

    // R7: master NACK ends the read
    i2c_start(); send_byte(8'hD3, a);
    recv_byte(1'b1, b); chk(b == 8'h07, "R6 byte count", b, 8'h07);
    recv_byte(1'b0, b); chk(b == model[0], "R7 byte before NACK", b, model[0]);
    recv_byte(1'b0, b); chk(b == 8'hFF, "R7 SDA released after NACK", b, 8'hFF);
    i2c_stop();

    // R11: write, repeated START, read back
    i2c_start(); send_byte(8'hD2, a); send_byte(8'h01, a); send_byte(8'h01, a);
    send_byte(8'h77, a); model[0] = 8'h77;
    i2c_start(); send_byte(8'hD3, a);
    chk(a, "R11 address after repeated START acked", a, 1);
    for (int k = 0; k <= NREG; k++) begin
      recv_byte(k < NREG, b);
      chk(b == exp_read(k), "R11 read after repeated START", b, exp_read(k));
    end
    i2c_stop();

    // Random writes of 0..8 data bytes, each read back
    for (int r = 0; r < 10; r++) begin
      int n;
      n = $urandom_range(0, 8);
      for (int j = 0; j < 8; j++) d[j] = 8'($urandom());
      write_txn(n, d);
      read_all("R4 random");
    end

    chk(bad_drive == 0, "R10 drive started only with SCL low", bad_drive, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule